// File: doc/BRIEF.md
# Single-Cycle RV32I Subset Processor Core

This block is a 32-bit RISC-V processor that completes each instruction in one clock: fetch, decode, register read, execute, data access and write-back all happen between two rising edges. It recognises only the twelve RV32I instructions that a compiled Tausworthe pseudorandom-number program needs. Any other encoding is flagged as illegal and is never executed. The pseudo-instructions li, mv, ret, jr and a relaxed call are all built from those twelve.

The core holds a word-indexed instruction ROM. Its contents come from a program function in the package: the generator seeds itself and draws twenty numbers, storing each one at a fixed data address. It also holds a byte-addressed data RAM that serves as the stack, and a 32-entry register file. Execution starts at a parameterised entry address, the start of the main routine. The stack pointer leaves reset pointing at the top of the data RAM. A debug port shows the PC, the instruction word being fetched, a retire strobe, an illegal flag, a free-running cycle count and every store the core makes. Software on the host can therefore follow the run, and can tell from the cycle count how long the program took.

Top module: `rvs_core`

## Requirements
- R1: Reset is synchronous and active-low. While it is held, the debug port shows PC = ENTRY_PC, a cycle count of 0, retire low and no store. After reset, x2 holds STACK_INIT and every other register holds 0.
- R2: The legal encodings are defined by opcode (bits 6:0) and funct3 (bits 14:12); funct7 is bits 31:25.
  - 0x37: lui.
  - 0x13: addi (funct3 0), andi (funct3 7), slli (funct3 1, funct7 0) and srli (funct3 5, funct7 0).
  - 0x33 with funct7 0: xor (funct3 4) and and (funct3 7).
  - 0x03: lw (funct3 2).
  - 0x23: sw (funct3 2).
  - 0x6F: jal.
  - 0x67: jalr (funct3 0).
  - 0x63: bne (funct3 1).
  - Every other word is illegal.
- R3: A write to x0 is discarded, and x0 always reads as zero.
- R4: Each ALU instruction writes its result to rd in the same cycle:
  - addi and andi combine rs1 with the sign-extended 12-bit immediate.
  - slli and srli are logical shifts by a 5-bit amount.
  - xor and and combine two registers.
  - lui places imm[31:12] over twelve zero bits.
- R5: lw and sw move whole 32-bit words at the address rs1 + sign-extended offset. The RAM word is selected by address bits [log2(RAM_WORDS)+1:2], so higher addresses alias. Every sw shows strobe, full address and rs2 data on the store port in its own cycle.
- R6: bne jumps to PC + sign-extended 13-bit B-immediate when rs1 differs from rs2. Otherwise the PC advances by 4.
- R7: jal writes PC+4 to rd and jumps to PC + sign-extended 21-bit J-immediate.
- R8: jalr writes PC+4 to rd and jumps to (rs1 + imm) with bit 0 forced to zero.
- R9: An illegal instruction raises the illegal flag. While it is fetched, the PC holds, no register or memory is written, and retire stays low.
- R10: The cycle count increases by exactly one on every clock after reset.
- R11: Retire is high in every cycle that executes a legal instruction. Every retired instruction that is not jal, jalr or bne advances the PC by 4.
- R12: With the default program, the core stores twenty generator outputs at address 0x110. The last one is 0x9B9A9C65, the twentieth output for seed 12345678. The core then halts on the illegal word at address 0xF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| dbg_pc | output | 32 | PC of the instruction in this cycle |
| dbg_instr | output | 32 | Instruction word fetched at dbg_pc |
| dbg_retire | output | 1 | A legal instruction completes this cycle |
| dbg_illegal | output | 1 | The fetched word is not in the supported set |
| dbg_cycle | output | CYC_W | Free-running cycle count since reset |
| dbg_st_en | output | 1 | A store writes data RAM at the next edge |
| dbg_st_addr | output | 32 | Byte address of that store |
| dbg_st_data | output | 32 | Word written by that store |

## Verification
The bench's instruction-level model targets several corner cases, and each one has a visible failure signature:
- The program writes 77 into x0 before the seed routine stores zero twice. A core that kept the value would plant 77 in two generator states and corrupt every later number.
- The seed routine is entered through jalr with an odd target. A core that kept bit 0 would fetch from a misaligned PC, which the per-cycle PC comparison catches.
- The loop-closing bne runs both taken and not taken. A wrong comparison would either never leave the loop or leave it after one pass.
- The final halt must freeze the PC while the cycle count keeps running. A core that skipped the illegal word would run on into empty ROM and store or jump where the model does not.

// File: rtl/rvs_pkg.sv
// Package rvs_pkg
// Shared opcodes, control types, small encoders and the default program
// image for the single-cycle core. Assumes RV32I base encodings.
package rvs_pkg;

    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_AND, ALU_XOR, ALU_SLL, ALU_SRL, ALU_PASSB
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_ALU, WB_MEM, WB_LINK
    } wb_sel_e;

    typedef struct packed {
        logic        illegal;
        logic        reg_we;
        logic        mem_we;
        logic        use_imm;
        logic        is_bne;
        logic        is_jal;
        logic        is_jalr;
        alu_op_e     alu_op;
        wb_sel_e     wb_sel;
        logic [31:0] imm;
    } ctrl_t;

    // register numbers used by the program image
    localparam logic [4:0] X0 = 5'd0,  RA = 5'd1,  SP = 5'd2,  T1 = 5'd6;
    localparam logic [4:0] S0 = 5'd8,  S1 = 5'd9,  A0 = 5'd10, A1 = 5'd11;
    localparam logic [4:0] A2 = 5'd12, A3 = 5'd13, A4 = 5'd14, A5 = 5'd15;
    localparam logic [4:0] S2 = 5'd18;

    function automatic logic [31:0] enc_i(logic [6:0] op, logic [2:0] f3,
                                          logic [4:0] rd, logic [4:0] rs1, int imm);
        logic [11:0] v;
        v = 12'(imm);
        return {v, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] enc_sh(logic [2:0] f3, logic [4:0] rd,
                                           logic [4:0] rs1, int sh);
        logic [4:0] v;
        v = 5'(sh);
        return {7'b0, v, rs1, f3, rd, OPC_OPIMM};
    endfunction

    function automatic logic [31:0] enc_r(logic [2:0] f3, logic [4:0] rd,
                                          logic [4:0] rs1, logic [4:0] rs2);
        return {7'b0, rs2, rs1, f3, rd, OPC_OP};
    endfunction

    function automatic logic [31:0] enc_sw(logic [4:0] rs2, logic [4:0] rs1, int imm);
        logic [11:0] v;
        v = 12'(imm);
        return {v[11:5], rs2, rs1, 3'b010, v[4:0], OPC_STORE};
    endfunction

    function automatic logic [31:0] enc_bne(logic [4:0] rs1, logic [4:0] rs2, int imm);
        logic [12:0] v;
        v = 13'(imm);
        return {v[12], v[10:5], rs2, rs1, 3'b001, v[4:1], v[11], OPC_BRANCH};
    endfunction

    function automatic logic [31:0] enc_lui(logic [4:0] rd, int imm);
        logic [19:0] v;
        v = 20'(imm);
        return {v, rd, OPC_LUI};
    endfunction

    function automatic logic [31:0] enc_jal(logic [4:0] rd, int imm);
        logic [20:0] v;
        v = 21'(imm);
        return {v[20], v[10:1], v[11], v[19:12], rd, OPC_JAL};
    endfunction

    // Default image: seed routine at 0x00, generator step at 0x14,
    // main at 0x9C, illegal halt word at 0xF0. State words at 0x100..0x10C,
    // each output is stored at 0x110.
    function automatic logic [31:0] prog_word(int idx);
        logic [31:0] w;
        case (idx)
            0:  w = enc_lui(A5, 0);
            1:  w = enc_sw(A0, A5, 'h100);
            2:  w = enc_sw(X0, A5, 'h104);
            3:  w = enc_sw(X0, A5, 'h108);
            4:  w = enc_i(OPC_JALR, 3'b000, X0, RA, 0);
            5:  w = enc_lui(A4, 0);
            6:  w = enc_i(OPC_LOAD, 3'b010, A5, A4, 'h100);
            7:  w = enc_sh(3'b001, A0, A5, 13);
            8:  w = enc_r(3'b100, A0, A0, A5);
            9:  w = enc_sh(3'b101, A0, A0, 19);
            10: w = enc_sh(3'b001, A5, A5, 12);
            11: w = enc_lui(A3, 'hFFFFE);
            12: w = enc_r(3'b111, A5, A5, A3);
            13: w = enc_r(3'b100, A0, A0, A5);
            14: w = enc_sw(A0, A4, 'h100);
            15: w = enc_lui(A3, 0);
            16: w = enc_i(OPC_LOAD, 3'b010, A5, A3, 'h104);
            17: w = enc_sh(3'b001, A4, A5, 2);
            18: w = enc_r(3'b100, A4, A4, A5);
            19: w = enc_sh(3'b101, A4, A4, 25);
            20: w = enc_sh(3'b001, A5, A5, 4);
            21: w = enc_i(OPC_OPIMM, 3'b111, A5, A5, -128);
            22: w = enc_r(3'b100, A4, A4, A5);
            23: w = enc_sw(A4, A3, 'h104);
            24: w = enc_lui(A2, 0);
            25: w = enc_i(OPC_LOAD, 3'b010, A5, A2, 'h108);
            26: w = enc_sh(3'b001, A3, A5, 3);
            27: w = enc_r(3'b100, A3, A3, A5);
            28: w = enc_sh(3'b101, A3, A3, 11);
            29: w = enc_lui(A1, 0);
            30: w = enc_sw(A3, A1, 'h10C);
            31: w = enc_sh(3'b001, A5, A5, 17);
            32: w = enc_lui(A1, 'hFFE00);
            33: w = enc_r(3'b111, A5, A5, A1);
            34: w = enc_r(3'b100, A5, A5, A3);
            35: w = enc_sw(A5, A2, 'h108);
            36: w = enc_r(3'b100, A0, A0, A4);
            37: w = enc_r(3'b100, A0, A0, A5);
            38: w = enc_i(OPC_JALR, 3'b000, X0, RA, 0);
            39: w = enc_i(OPC_OPIMM, 3'b000, X0, X0, 77);
            40: w = enc_i(OPC_OPIMM, 3'b000, SP, SP, -16);
            41: w = enc_sw(RA, SP, 12);
            42: w = enc_sw(S0, SP, 8);
            43: w = enc_sw(S1, SP, 4);
            44: w = enc_sw(S2, SP, 0);
            45: w = enc_lui(A0, 'hBC6);
            46: w = enc_i(OPC_OPIMM, 3'b000, A0, A0, 334);
            47: w = enc_i(OPC_OPIMM, 3'b000, T1, X0, 1);
            48: w = enc_i(OPC_JALR, 3'b000, RA, T1, 0);
            49: w = enc_i(OPC_OPIMM, 3'b000, S0, X0, 0);
            50: w = enc_i(OPC_OPIMM, 3'b000, S1, X0, 20);
            51: w = enc_jal(RA, -184);
            52: w = enc_sw(A0, X0, 'h110);
            53: w = enc_i(OPC_OPIMM, 3'b000, S0, S0, 1);
            54: w = enc_bne(S0, S1, -12);
            55: w = enc_i(OPC_LOAD, 3'b010, RA, SP, 12);
            56: w = enc_i(OPC_LOAD, 3'b010, S0, SP, 8);
            57: w = enc_i(OPC_LOAD, 3'b010, S1, SP, 4);
            58: w = enc_i(OPC_LOAD, 3'b010, S2, SP, 0);
            59: w = enc_i(OPC_OPIMM, 3'b000, SP, SP, 16);
            default: w = 32'h0000_0000;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rvs_decode.sv
// Module rvs_decode
// Turns one instruction word into a control bundle and a sign-extended
// immediate. Pure combinational. Any encoding outside the supported
// twelve instructions leaves illegal set and all write enables clear.
module rvs_decode
    import rvs_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctrl
);

    logic [6:0]  opc;
    logic [2:0]  f3;
    logic [6:0]  f7;
    logic [31:0] imm_i, imm_s, imm_b, imm_u, imm_j;

    // field split and immediate formats
    always_comb begin
        opc   = instr[6:0];
        f3    = instr[14:12];
        f7    = instr[31:25];
        imm_i = {{20{instr[31]}}, instr[31:20]};
        imm_s = {{20{instr[31]}}, instr[31:25], instr[11:7]};
        imm_b = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
        imm_u = {instr[31:12], 12'b0};
        imm_j = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
    end

    // control generation per opcode
    always_comb begin
        ctrl         = '0;
        ctrl.illegal = 1'b1;
        ctrl.alu_op  = ALU_ADD;
        ctrl.wb_sel  = WB_ALU;
        ctrl.imm     = imm_i;
        case (opc)
            OPC_LUI: begin
                ctrl.illegal = 1'b0;
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_PASSB;
                ctrl.imm     = imm_u;
            end
            OPC_OPIMM: begin
                ctrl.use_imm = 1'b1;
                case (f3)
                    3'b000: begin ctrl.illegal = 1'b0; ctrl.alu_op = ALU_ADD; end
                    3'b111: begin ctrl.illegal = 1'b0; ctrl.alu_op = ALU_AND; end
                    3'b001: if (f7 == 7'd0) begin ctrl.illegal = 1'b0; ctrl.alu_op = ALU_SLL; end
                    3'b101: if (f7 == 7'd0) begin ctrl.illegal = 1'b0; ctrl.alu_op = ALU_SRL; end
                    default: ;
                endcase
                ctrl.reg_we = !ctrl.illegal;
            end
            OPC_OP: begin
                if (f7 == 7'd0) begin
                    if (f3 == 3'b100) begin ctrl.illegal = 1'b0; ctrl.alu_op = ALU_XOR; end
                    if (f3 == 3'b111) begin ctrl.illegal = 1'b0; ctrl.alu_op = ALU_AND; end
                end
                ctrl.reg_we = !ctrl.illegal;
            end
            OPC_LOAD: if (f3 == 3'b010) begin
                ctrl.illegal = 1'b0;
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.wb_sel  = WB_MEM;
            end
            OPC_STORE: if (f3 == 3'b010) begin
                ctrl.illegal = 1'b0;
                ctrl.mem_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.imm     = imm_s;
            end
            OPC_JAL: begin
                ctrl.illegal = 1'b0;
                ctrl.reg_we  = 1'b1;
                ctrl.is_jal  = 1'b1;
                ctrl.wb_sel  = WB_LINK;
                ctrl.imm     = imm_j;
            end
            OPC_JALR: if (f3 == 3'b000) begin
                ctrl.illegal = 1'b0;
                ctrl.reg_we  = 1'b1;
                ctrl.is_jalr = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.wb_sel  = WB_LINK;
            end
            OPC_BRANCH: if (f3 == 3'b001) begin
                ctrl.illegal = 1'b0;
                ctrl.is_bne  = 1'b1;
                ctrl.imm     = imm_b;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rvs_regfile.sv
// Module rvs_regfile
// 32 x 32-bit register file, two combinational read ports, one write
// port taken at the rising edge. Writes to entry 0 are dropped. Reset
// loads the stack pointer (entry 2) with SP_INIT and clears the rest.
module rvs_regfile #(
    parameter logic [31:0] SP_INIT = 32'h0000_0400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  ra1,
    input  logic [4:0]  ra2,
    output logic [31:0] rd1,
    output logic [31:0] rd2,
    input  logic        we,
    input  logic [4:0]  wa,
    input  logic [31:0] wd
);

    localparam int NREG = 32;
    logic [31:0] regs [NREG];

    // reset and write-back of the register array
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= (i == 2) ? SP_INIT : 32'h0;
        end else if (we && (wa != 5'd0)) begin
            regs[wa] <= wd;
        end
    end

    // combinational read ports
    always_comb begin
        rd1 = regs[ra1];
        rd2 = regs[ra2];
    end

    assert_x0_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0] == 32'h0);

endmodule

// File: rtl/rvs_alu.sv
// Module rvs_alu
// Combinational ALU for the supported subset: add, and, xor, logical
// left and right shifts by b[4:0], and a pass of operand b for lui.
module rvs_alu
    import rvs_pkg::*;
(
    input  alu_op_e     op,
    input  logic [31:0] a,
    input  logic [31:0] b,
    output logic [31:0] y
);

    // operation select
    always_comb begin
        case (op)
            ALU_ADD:   y = a + b;
            ALU_AND:   y = a & b;
            ALU_XOR:   y = a ^ b;
            ALU_SLL:   y = a << b[4:0];
            ALU_SRL:   y = a >> b[4:0];
            ALU_PASSB: y = b;
            default:   y = 32'h0;
        endcase
    end

endmodule

// File: rtl/rvs_dmem.sv
// Module rvs_dmem
// Word-wide data RAM used for globals and stack. Read is combinational,
// write lands at the rising edge. The caller hands in the word index,
// so byte addresses alias modulo the RAM size. No reset of contents.
module rvs_dmem #(
    parameter int WORDS = 256,
    localparam int IW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);

    logic [31:0] mem [WORDS];

    // store port
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // load port
    always_comb rdata = mem[idx];

endmodule

// File: rtl/rvs_core.sv
// Module rvs_core
// Single-cycle RV32I-subset core: ROM fetch at PC, decode, register read,
// ALU, data RAM access and write-back within one clock. Illegal words
// freeze the PC and suppress every write. Assumes the ROM image comes
// from rvs_pkg::prog_word and that PC stays word aligned.
module rvs_core
    import rvs_pkg::*;
#(
    parameter logic [31:0] ENTRY_PC   = 32'h0000_009C,
    parameter logic [31:0] STACK_INIT = 32'h0000_0400,
    parameter int          ROM_WORDS  = 64,
    parameter int          RAM_WORDS  = 256,
    parameter int          CYC_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [31:0]      dbg_pc,
    output logic [31:0]      dbg_instr,
    output logic             dbg_retire,
    output logic             dbg_illegal,
    output logic [CYC_W-1:0] dbg_cycle,
    output logic             dbg_st_en,
    output logic [31:0]      dbg_st_addr,
    output logic [31:0]      dbg_st_data
);

    localparam int          ROM_IW    = $clog2(ROM_WORDS);
    localparam int          RAM_IW    = $clog2(RAM_WORDS);
    localparam logic [29:0] ROM_LIMIT = 30'(ROM_WORDS);

    logic [31:0]      pc_q, pc_nx, pc_plus4, pc_rel, instr;
    logic [31:0]      rs1v, rs2v, alu_b, alu_y, mem_rd, wb_data;
    logic [CYC_W-1:0] cyc_q;
    logic             mem_we, reg_we;
    ctrl_t            c;
    logic [31:0]      rom [ROM_WORDS];

    // ROM image built from the package program function
    for (genvar g = 0; g < ROM_WORDS; g++) begin : g_rom
        assign rom[g] = prog_word(g);
    end

    // fetch: outside the ROM reads as an all-zero (illegal) word
    always_comb begin
        instr = (pc_q[31:2] < ROM_LIMIT) ? rom[pc_q[ROM_IW+1:2]] : 32'h0;
    end

    rvs_decode u_dec (
        .instr (instr),
        .ctrl  (c)
    );

    rvs_regfile #(.SP_INIT(STACK_INIT)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (instr[19:15]),
        .ra2   (instr[24:20]),
        .rd1   (rs1v),
        .rd2   (rs2v),
        .we    (reg_we),
        .wa    (instr[11:7]),
        .wd    (wb_data)
    );

    // second ALU operand select
    always_comb alu_b = c.use_imm ? c.imm : rs2v;

    rvs_alu u_alu (
        .op (c.alu_op),
        .a  (rs1v),
        .b  (alu_b),
        .y  (alu_y)
    );

    rvs_dmem #(.WORDS(RAM_WORDS)) u_dm (
        .clk   (clk),
        .we    (mem_we),
        .idx   (alu_y[RAM_IW+1:2]),
        .wdata (rs2v),
        .rdata (mem_rd)
    );

    // write enables gated by legality and reset
    always_comb begin
        reg_we = c.reg_we && !c.illegal && rst_n;
        mem_we = c.mem_we && !c.illegal && rst_n;
    end

    // write-back select
    always_comb begin
        pc_plus4 = pc_q + 32'd4;
        pc_rel   = pc_q + c.imm;
        case (c.wb_sel)
            WB_MEM:  wb_data = mem_rd;
            WB_LINK: wb_data = pc_plus4;
            default: wb_data = alu_y;
        endcase
    end

    // next-PC selection
    always_comb begin
        if (c.illegal)                          pc_nx = pc_q;
        else if (c.is_jal)                      pc_nx = pc_rel;
        else if (c.is_bne && (rs1v != rs2v))    pc_nx = pc_rel;
        else if (c.is_jalr)                     pc_nx = {alu_y[31:1], 1'b0};
        else                                    pc_nx = pc_plus4;
    end

    // PC register
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= ENTRY_PC;
        else        pc_q <= pc_nx;
    end

    // free-running cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_q + 1'b1;
    end

    // debug port
    always_comb begin
        dbg_pc      = pc_q;
        dbg_instr   = instr;
        dbg_retire  = rst_n && !c.illegal;
        dbg_illegal = c.illegal;
        dbg_cycle   = cyc_q;
        dbg_st_en   = mem_we;
        dbg_st_addr = alu_y;
        dbg_st_data = rs2v;
    end

    assert_class_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({c.is_bne, c.is_jal, c.is_jalr, c.mem_we}));

    assert_illegal_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        c.illegal |-> (!c.reg_we && !c.mem_we));

    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_illegal |=> $stable(pc_q));

    assert_cycle_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cyc_q == $past(cyc_q) + 1'b1));

    assert_seq_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_retire && !c.is_jal && !c.is_jalr && !c.is_bne) |=> (pc_q == $past(pc_q) + 32'd4));

    assert_bne_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_retire && c.is_bne && (rs1v != rs2v)) |=> (pc_q == $past(pc_q + c.imm)));

    assert_jalr_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_retire && c.is_jalr) |=> !pc_q[0]);

endmodule

// File: tb/sim_rvs_core.sv
// Bench for rvs_core: an instruction-level reference model steps on every
// clock and is compared with the debug port; generator outputs are checked
// against a behavioural Tausworthe computation.
module sim_rvs_core;

    localparam logic [31:0] ENTRY = 32'h0000_009C;
    localparam logic [31:0] SP0   = 32'h0000_0400;
    localparam int          RAMW  = 256;
    localparam logic [31:0] OUT_ADDR = 32'h0000_0110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dbg_pc, dbg_instr, dbg_st_addr, dbg_st_data, dbg_cycle;
    logic        dbg_retire, dbg_illegal, dbg_st_en;

    always #2 clk = ~clk;

    rvs_core #(.ENTRY_PC(ENTRY), .STACK_INIT(SP0), .ROM_WORDS(64),
               .RAM_WORDS(RAMW), .CYC_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .dbg_pc(dbg_pc), .dbg_instr(dbg_instr),
        .dbg_retire(dbg_retire), .dbg_illegal(dbg_illegal), .dbg_cycle(dbg_cycle),
        .dbg_st_en(dbg_st_en), .dbg_st_addr(dbg_st_addr), .dbg_st_data(dbg_st_data)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model state
    logic [31:0] mx [32];
    logic [31:0] mmem [int];
    logic [31:0] mpc;
    int          mcyc;
    logic [31:0] gold [20];
    int          res_n = 0;
    logic [31:0] last_res = 32'h0;
    int          halt_n = 0;
    int          taken_n = 0, fall_n = 0;
    bit          done = 1'b0;
    string       pc_tag = "R1 entry";

    function automatic bit legal_of(logic [31:0] w);
        logic [2:0] f3 = w[14:12];
        logic [6:0] f7 = w[31:25];
        case (w[6:0])
            7'h37: return 1'b1;
            7'h13: return (f3 == 3'd0) || (f3 == 3'd7) ||
                          (((f3 == 3'd1) || (f3 == 3'd5)) && f7 == 7'd0);
            7'h33: return ((f3 == 3'd4) || (f3 == 3'd7)) && f7 == 7'd0;
            7'h03: return f3 == 3'd2;
            7'h23: return f3 == 3'd2;
            7'h6F: return 1'b1;
            7'h67: return f3 == 3'd0;
            7'h63: return f3 == 3'd1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int widx(logic [31:0] a);
        return int'((a >> 2) & (RAMW - 1));
    endfunction

    task automatic wr(input logic [4:0] rd, input logic [31:0] v);
        if (rd != 5'd0) mx[rd] = v;   // R3: x0 never changes
    endtask

    task automatic step();
        logic [31:0] w, a, b, ii, is, ib, ij, npc, addr, t;
        logic [4:0]  rd, rs1, rs2;
        logic [2:0]  f3;
        bit          lg;
        w   = dbg_instr;
        rd  = w[11:7]; rs1 = w[19:15]; rs2 = w[24:20]; f3 = w[14:12];
        ii  = {{20{w[31]}}, w[31:20]};
        is  = {{20{w[31]}}, w[31:25], w[11:7]};
        ib  = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
        ij  = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
        a   = mx[rs1];
        b   = mx[rs2];
        lg  = legal_of(w);
        chk({pc_tag, " pc"}, dbg_pc, mpc);
        chk("R10 cycle count", dbg_cycle, 32'(mcyc));
        chk("R2 R9 illegal flag", {31'b0, dbg_illegal}, {31'b0, !lg});
        chk("R11 retire strobe", {31'b0, dbg_retire}, {31'b0, lg});
        chk("R5 R9 store strobe", {31'b0, dbg_st_en}, {31'b0, lg && w[6:0] == 7'h23});
        npc = mpc + 32'd4;
        pc_tag = "R11 sequential";
        if (lg) begin
            halt_n = 0;
            case (w[6:0])
                7'h37: wr(rd, {w[31:12], 12'b0});
                7'h13: case (f3)
                    3'd0: wr(rd, a + ii);
                    3'd7: wr(rd, a & ii);
                    3'd1: wr(rd, a << w[24:20]);
                    default: wr(rd, a >> w[24:20]);
                endcase
                7'h33: wr(rd, (f3 == 3'd4) ? (a ^ b) : (a & b));
                7'h03: begin
                    addr = a + ii;
                    wr(rd, mmem.exists(widx(addr)) ? mmem[widx(addr)] : 32'h0);
                end
                7'h23: begin
                    addr = a + is;
                    chk("R5 store address", dbg_st_addr, addr);
                    chk("R4 R5 R3 store data", dbg_st_data, b);
                    mmem[widx(addr)] = b;
                    if (addr == OUT_ADDR) begin
                        if (res_n < 20) chk("R12 generator output", b, gold[res_n]);
                        res_n++;
                        last_res = b;
                    end
                end
                7'h6F: begin
                    wr(rd, mpc + 32'd4);
                    npc = mpc + ij;
                    pc_tag = "R7 jal";
                end
                7'h67: begin
                    t = a + ii;
                    wr(rd, mpc + 32'd4);
                    npc = {t[31:1], 1'b0};
                    pc_tag = "R8 jalr";
                end
                default: begin
                    if (a != b) begin npc = mpc + ib; taken_n++; end
                    else fall_n++;
                    pc_tag = "R6 bne";
                end
            endcase
            mpc = npc;
        end else begin
            pc_tag = "R9 halted";
            halt_n++;
            if (halt_n >= 6) done = 1'b1;
        end
        mcyc++;
    endtask

    initial begin
        logic [31:0] s0, s1, s2, bb;
        // behavioural generator outputs for seed 12345678
        s0 = 32'd12345678; s1 = 32'd0; s2 = 32'd0;
        for (int k = 0; k < 20; k++) begin
            bb = ((s0 << 13) ^ s0) >> 19; s0 = ((s0 & 32'hFFFF_FFFE) << 12) ^ bb;
            bb = ((s1 << 2) ^ s1) >> 25;  s1 = ((s1 & 32'hFFFF_FFF8) << 4) ^ bb;
            bb = ((s2 << 3) ^ s2) >> 11;  s2 = ((s2 & 32'hFFFF_FFF0) << 17) ^ bb;
            gold[k] = s0 ^ s1 ^ s2;
        end

        // R1: state while reset is held
        repeat (3) begin
            @(negedge clk);
            chk("R1 reset pc", dbg_pc, ENTRY);
            chk("R1 reset cycle", dbg_cycle, 32'h0);
            chk("R1 reset retire", {31'b0, dbg_retire}, 32'h0);
            chk("R1 reset store", {31'b0, dbg_st_en}, 32'h0);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 32; i++) mx[i] = 32'h0;
        mx[2] = SP0;
        mpc   = ENTRY;
        mcyc  = 0;

        for (int n = 0; n < 5000 && !done; n++) begin
            @(negedge clk);
            step();
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL R12 watchdog expired actual=%h expected=%h", dbg_pc, 32'h0000_00F0);
        end

        chk("R12 output count", 32'(res_n), 32'd20);
        chk("R12 final output", last_res, 32'h9B9A9C65);
        chk("R9 halt address", dbg_pc, 32'h0000_00F0);
        chk("R6 bne taken seen", {31'b0, taken_n > 0}, 32'h1);
        chk("R6 bne fall-through seen", {31'b0, fall_n > 0}, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule